// File: doc/BRIEF.md
# Rule Update Decoder

This block holds the per-stride bit-vector tables and the per-rule valid bits of a small packet classifier, and applies live rule updates to them. An update arrives as a one-cycle command made of an opcode, a rule slot number and a prefix length. The rule value itself is taken from the header input bus during that same cycle, so no separate pins carry rule contents. Header lookups share the block with updates. A lookup presents a header and receives, one cycle later, a vector with one bit per rule that marks every active rule whose prefix covers the header.

When a command is accepted, the block checks the target slot against its valid bit. For insert and modify, it then writes the rule into every stride table, one table entry per cycle: the rule's bit in each entry is set where the entry index agrees with the rule value under its mask, and cleared elsewhere. For insert, the valid bit is set only after the last entry is written. Delete clears only the valid bit. A busy flag covers the whole operation, and while it is high the block ignores both header lookups and further commands. Each command ends with a one-cycle completion pulse and an error flag.

Top module: `rule_update_decoder`

## Requirements
- R1: After reset no rule is valid, and busy, upd_done, upd_err and match_vld are all low.
- R2: A header presented with hdr_vld while the block is idle and upd_vld is low yields match_vld one cycle later. In that cycle, bit r of match_vec is 1 exactly when slot r is valid and the top plen bits of the header (bit L-1 first) equal the top plen bits of the rule value. A rule with plen 0 matches every header; a rule with plen L matches only its own value.
- R3: Opcode 01 is insert. When the target slot is invalid, busy is high for exactly 2^S cycles. In those cycles tbl_we is high and tbl_idx counts 0 to 2^S-1, and the slot becomes valid only after the last write.
- R4: Opcode 10 is delete. When the target slot is valid, busy is high for one cycle and no table write is made. Afterwards the rule matches no header.
- R5: Opcode 11 is modify. When the target slot is valid, it takes 2^S cycles, as insert does. Afterwards the rule matches according to its new value and length only.
- R6: Insert on a valid slot, delete or modify on an invalid slot, and opcode 00 are all rejected. Busy is high for one cycle, no table write is made, upd_err is raised with upd_done, and lookup results are unchanged.
- R7: While busy is high, hdr_vld produces no match_vld, and upd_vld starts no new command. A command and a header presented in the same idle cycle start the command and produce no lookup result.
- R8: During a table write, bit k of tbl_bit is the new rule bit for stride k, entry tbl_idx. Stride 0 covers header bits L-1 down to L-S. The bit is 1 exactly when the entry index equals the rule's stride-k chunk on every bit that lies within the top plen bits.
- R9: Every command ends with exactly one upd_done pulse. It comes in the cycle after busy falls and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_in | input | L | Header for lookups; rule value during a command cycle |
| hdr_vld | input | 1 | Lookup request |
| upd_vld | input | 1 | Command request |
| upd_op | input | 2 | 00 reserved, 01 insert, 10 delete, 11 modify |
| upd_rid | input | log2(N) | Target rule slot |
| upd_plen | input | log2(L+1) | Prefix length of the new rule |
| busy | output | 1 | Command in progress; lookups and commands blocked |
| upd_done | output | 1 | One-cycle command completion pulse |
| upd_err | output | 1 | Command rejected (valid with upd_done) |
| tbl_we | output | 1 | Table write this cycle |
| tbl_idx | output | S | Table entry being written |
| tbl_rid | output | log2(N) | Rule bit column being written |
| tbl_bit | output | NSTR | New bit for each stride table |
| match_vld | output | 1 | Lookup result valid |
| match_vec | output | N | Per-rule match result |

## Verification
The bench sweeps every header after each batch of updates. A wrong mask split across a stride boundary, or a mishandled zero or full prefix length, therefore shows up as a wrong bit for some header. The bench repeats an insert on a live slot, and deletes and modifies empty slots. A decoder that skipped the slot check would overwrite a live rule or revive a dead one, and the following sweep would show it. During every busy window the bench keeps a lookup and a spurious delete on the inputs. A block that leaked either would give an early match result or lose a rule. Each write cycle is compared with its expected entry index and stride bits, so an out-of-order or duplicated entry write is caught.

// File: rtl/rule_update_decoder.sv
module rule_update_decoder #(
  parameter int N    = 8,
  parameter int S    = 2,
  parameter int NSTR = 3,
  localparam int L   = NSTR * S,
  localparam int RW  = $clog2(N),
  localparam int PW  = $clog2(L + 1),
  localparam int E   = 1 << S
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [L-1:0]    hdr_in,
  input  logic            hdr_vld,
  input  logic            upd_vld,
  input  logic [1:0]      upd_op,
  input  logic [RW-1:0]   upd_rid,
  input  logic [PW-1:0]   upd_plen,
  output logic            busy,
  output logic            upd_done,
  output logic            upd_err,
  output logic            tbl_we,
  output logic [S-1:0]    tbl_idx,
  output logic [RW-1:0]   tbl_rid,
  output logic [NSTR-1:0] tbl_bit,
  output logic            match_vld,
  output logic [N-1:0]    match_vec
);
  localparam logic [1:0] OP_INS = 2'b01, OP_DEL = 2'b10;

  logic [N-1:0]  tbl [NSTR][E];
  logic [N-1:0]  valid;
  logic [1:0]    op_q;
  logic [RW-1:0] rid_q;
  logic [L-1:0]  val_q;
  logic [PW-1:0] plen_q;
  logic          err_q;
  logic [S-1:0]  cnt;
  logic [N-1:0]  hit;
  logic          accept, bad;

  assign accept  = upd_vld & ~busy;
  assign bad     = (upd_op == 2'b00) | ((upd_op == OP_INS) == valid[upd_rid]);
  assign tbl_we  = busy & op_q[0] & ~err_q;
  assign tbl_idx = cnt;
  assign tbl_rid = rid_q;

  always_comb begin
    for (int k = 0; k < NSTR; k++) begin
      logic diff;
      diff = 1'b0;
      for (int j = 0; j < S; j++) begin
        int pos;
        pos = k * S + (S - 1 - j);
        if (pos < int'(plen_q))
          diff = diff | (cnt[j] ^ val_q[L-1-pos]);
      end
      tbl_bit[k] = ~diff;
    end
  end

  always_comb begin
    hit = valid;
    for (int k = 0; k < NSTR; k++)
      hit = hit & tbl[k][hdr_in[L-1-k*S -: S]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0; busy <= 1'b0; upd_done <= 1'b0; upd_err <= 1'b0;
      match_vld <= 1'b0; match_vec <= '0; cnt <= '0;
      op_q <= '0; rid_q <= '0; val_q <= '0; plen_q <= '0; err_q <= 1'b0;
      for (int k = 0; k < NSTR; k++)
        for (int e = 0; e < E; e++) tbl[k][e] <= '0;
    end else begin
      upd_done  <= 1'b0;
      upd_err   <= 1'b0;
      match_vld <= hdr_vld & ~busy & ~upd_vld;
      if (hdr_vld & ~busy & ~upd_vld) match_vec <= hit;
      if (accept) begin
        busy <= 1'b1; op_q <= upd_op; rid_q <= upd_rid; val_q <= hdr_in;
        plen_q <= upd_plen; err_q <= bad; cnt <= '0;
      end else if (busy) begin
        if (err_q) begin
          busy <= 1'b0; upd_done <= 1'b1; upd_err <= 1'b1;
        end else if (op_q == OP_DEL) begin
          valid[rid_q] <= 1'b0; busy <= 1'b0; upd_done <= 1'b1;
        end else begin
          for (int k = 0; k < NSTR; k++) tbl[k][cnt][rid_q] <= tbl_bit[k];
          cnt <= cnt + 1'b1;
          if (cnt == S'(E - 1)) begin
            valid[rid_q] <= 1'b1; busy <= 1'b0; upd_done <= 1'b1;
          end
        end
      end
    end
  end

  // R7
  busy_blocks_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !match_vld);
  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && tbl_idx != S'(E - 1)) |=> (tbl_we && tbl_idx == $past(tbl_idx) + 1'b1));
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> upd_done);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);
  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_err |-> (upd_done && !busy));
endmodule

// File: tb/rule_update_decoder_tb_top.sv
module rule_update_decoder_tb_top;
  localparam int N = 8, S = 2, NSTR = 3, L = NSTR * S, E = 1 << S;
  localparam int RW = $clog2(N), PW = $clog2(L + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [L-1:0] hdr_in = '0;
  logic hdr_vld = 1'b0, upd_vld = 1'b0;
  logic [1:0] upd_op = '0;
  logic [RW-1:0] upd_rid = '0;
  logic [PW-1:0] upd_plen = '0;
  logic busy, upd_done, upd_err, tbl_we, match_vld;
  logic [S-1:0] tbl_idx;
  logic [RW-1:0] tbl_rid;
  logic [NSTR-1:0] tbl_bit;
  logic [N-1:0] match_vec;

  int n_chk = 0, n_fail = 0;
  bit m_valid [N];
  int m_val [N];
  int m_plen [N];

  always #10 clk = ~clk;

  rule_update_decoder #(.N(N), .S(S), .NSTR(NSTR)) dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_in(hdr_in), .hdr_vld(hdr_vld),
    .upd_vld(upd_vld), .upd_op(upd_op), .upd_rid(upd_rid), .upd_plen(upd_plen),
    .busy(busy), .upd_done(upd_done), .upd_err(upd_err), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_rid(tbl_rid), .tbl_bit(tbl_bit),
    .match_vld(match_vld), .match_vec(match_vec));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_bit(int val, int plen, int k, int e);
    int chunk, c;
    chunk = (val >> (L - S * (k + 1))) & (E - 1);
    c = plen - k * S;
    if (c <= 0) return 1'b1;
    if (c > S) c = S;
    return (e >> (S - c)) == (chunk >> (S - c));
  endfunction

  function automatic int exp_match(int h);
    int v = 0;
    for (int r = 0; r < N; r++)
      if (m_valid[r] && (m_plen[r] == 0 || (h >> (L - m_plen[r])) == (m_val[r] >> (L - m_plen[r]))))
        v |= (1 << r);
    return v;
  endfunction

  task automatic sweep(input string req);
    for (int h = 0; h < (1 << L); h++) begin
      @(negedge clk);
      hdr_in = L'(h); hdr_vld = 1'b1;
      @(negedge clk);
      hdr_vld = 1'b0;
      chk(match_vld && match_vec == N'(exp_match(h)), req, $sformatf("lookup hdr %0d", h),
          int'(match_vec), exp_match(h));
    end
  endtask

  task automatic upd(input logic [1:0] op, input int rid, input int val, input int plen,
                     input bit exp_err, input string req);
    int busy_n = 0, we_n = 0, bad_n = 0, exp_busy, exp_we, guard = 0;
    exp_busy = exp_err ? 1 : (op == 2'b10 ? 1 : E);
    exp_we = (exp_err || op == 2'b10) ? 0 : E;
    @(negedge clk);
    upd_vld = 1'b1; upd_op = op; upd_rid = RW'(rid); upd_plen = PW'(plen);
    hdr_in = L'(val); hdr_vld = 1'b1;
    @(negedge clk);
    upd_op = 2'b10; upd_rid = RW'(rid ^ 1); hdr_in = '0;
    while (busy && guard < 100) begin
      guard++; busy_n++;
      if (match_vld) bad_n++;
      if (tbl_we) begin
        if (int'(tbl_idx) != we_n || int'(tbl_rid) != rid) bad_n++;
        for (int k = 0; k < NSTR; k++)
          if (tbl_bit[k] != exp_bit(val, plen, k, we_n)) bad_n++;
        we_n++;
      end
      @(negedge clk);
    end
    upd_vld = 1'b0; hdr_vld = 1'b0;
    chk(busy_n == exp_busy, req, "busy cycles", busy_n, exp_busy);
    chk(we_n == exp_we, req, "table writes", we_n, exp_we);
    chk(bad_n == 0, "R8", "write index/bits or lookup leak", bad_n, 0);
    chk(upd_done == 1'b1 && !match_vld, "R9", "done pulse", int'(upd_done), 1);
    chk(upd_err == exp_err, req, "error flag", int'(upd_err), int'(exp_err));
    @(negedge clk);
    chk(!upd_done && !busy, "R9", "done single pulse", int'(upd_done), 0);
    if (!exp_err) begin
      if (op == 2'b10) m_valid[rid] = 1'b0;
      else begin m_valid[rid] = 1'b1; m_val[rid] = val; m_plen[rid] = plen; end
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int r = 0; r < N; r++) begin m_valid[r] = 0; m_val[r] = 0; m_plen[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !upd_done && !upd_err && !match_vld, "R1", "reset outputs", int'(busy), 0);
    sweep("R1");
    upd(2'b01, 0, 6'b101100, 4, 1'b0, "R3");
    upd(2'b01, 1, 0, 0, 1'b0, "R3");
    upd(2'b01, 2, 63, 6, 1'b0, "R3");
    upd(2'b01, 5, 6'b010000, 2, 1'b0, "R3");
    upd(2'b01, 6, 6'b110110, 5, 1'b0, "R3");
    sweep("R2");
    upd(2'b01, 0, 6'b000000, 6, 1'b1, "R6");
    upd(2'b10, 3, 0, 0, 1'b1, "R6");
    upd(2'b11, 4, 7, 3, 1'b1, "R6");
    upd(2'b00, 1, 9, 2, 1'b1, "R6");
    sweep("R6");
    upd(2'b11, 0, 6'b000011, 6, 1'b0, "R5");
    upd(2'b10, 1, 0, 0, 1'b0, "R4");
    upd(2'b11, 6, 6'b011101, 3, 1'b0, "R5");
    sweep("R5");
    upd(2'b01, 1, 6'b111000, 3, 1'b0, "R3");
    upd(2'b01, 7, 6'b100101, 1, 1'b0, "R3");
    upd(2'b10, 2, 0, 0, 1'b0, "R4");
    sweep("R4");
    sweep("R7");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule